// File: doc/BRIEF.md
# Pooling Row-Pair Bank Steering

This block takes a stream of 64-bit beats, each holding four 16-bit pixels of a feature map in raster order. It spreads them over four narrow banks: upper-even, upper-odd, lower-even and lower-odd. A following 2x2 pooling stage can then fetch the four pixels of one window in a single read. The block tracks its position inside the current pair of rows from a configured row width. Every beat then splits into two pixel pairs, and each pair is routed to the bank picked by its row within the pair and by its column.

The row width must be even and at least 4. When it is a multiple of 4, every beat stays inside one row. When it leaves a remainder of 2, one beat per row pair straddles the row boundary. That beat's lower pair closes the upper row and its upper pair opens the lower row. In the lower row, the alternation between the two lower banks then starts one pair later. After the last beat of the lower row the block raises a one-cycle completion flag and starts over on the upper row of the next pair.

Top module: `mpd_row_steer`

## Requirements
- R1: During reset and in the first cycle after it, no bank write enable and no completion flag is high, and the first beat accepted after reset is placed at column 0 of the upper row.
- R2: A pair lying in the upper row at column c is written to bank 0 (upper-even) when bit 1 of c is 0 and to bank 1 (upper-odd) when it is 1. Bank indices are bit positions in `bank_we`.
- R3: A pair lying in the lower row at column c is written to bank 2 (lower-even) when bit 1 of c is 0 and to bank 3 (lower-odd) when it is 1. With a width of 2 modulo 4, this puts the lower row in lower-even, lower-odd order at column 0 but in lower-odd, lower-even order in every later beat.
- R4: When the width leaves a remainder of 2 modulo 4, the straddling beat writes its pixels 0 and 1 to bank 0 and its pixels 2 and 3 to bank 2 at address 0, in the same cycle.
- R5: The address of a pair at column c is c divided by 4, so every bank restarts at address 0 with each new row pair.
- R6: The completion flag is high for exactly one cycle, in the cycle that carries the write of the last pair of the lower row. The next beat lands at column 0 of the upper row.
- R7: Each accepted beat produces exactly two bank writes, one clock after it is presented. A cycle without a valid beat writes nothing and does not move the position.
- R8: Write data for a bank is the pair's two pixels, with the earlier pixel in bits 15:0. Beat pixel k occupies beat bits 16k+15:16k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| beat_valid | input | 1 | Beat present this cycle |
| beat_data | input | 64 | Four pixels, pixel 0 in the low bits |
| row_width | input | 7 | Pixels per row, even, 4 to 64, changed only under reset |
| bank_we | output | 4 | Write enable per bank (0 upper-even, 1 upper-odd, 2 lower-even, 3 lower-odd) |
| bank_addr | output | 16 | Four 4-bit addresses, bank b at bits 4b+3:4b |
| bank_wdata | output | 128 | Four 32-bit pixel pairs, bank b at bits 32b+31:32b |
| pair_ready | output | 1 | One-cycle flag: row pair complete |

## Verification
Two functions can coincide in one beat: closing the upper row and opening the lower one. With a width of 2 modulo 4, the straddling beat must write upper-even at the last upper address and lower-even at address 0 together. The run after that must keep the reversed lower-bank order up to the wrap, where the completion flag must appear with the last lower-row write. Widths 22 and 10 provoke this, with and without idle gaps between beats. A scoreboard model that places each pixel from its own column arithmetic judges every write and the flag, and widths 48 and 4 cover the aligned case against the same model.

// File: rtl/mpd_pkg.sv
package mpd_pkg;
  localparam int unsigned PIX_W   = 16;
  localparam int unsigned PIX_PER = 4;
  localparam int unsigned PAIRS   = PIX_PER / 2;
  localparam int unsigned NBANK   = 4;
  localparam int unsigned PAIR_W  = 2 * PIX_W;

  typedef enum logic [1:0] {
    BANK_UP_EVEN = 2'd0,
    BANK_UP_ODD  = 2'd1,
    BANK_LO_EVEN = 2'd2,
    BANK_LO_ODD  = 2'd3
  } bank_e;
endpackage

// File: rtl/mpd_pos_track.sv
module mpd_pos_track #(
  parameter int unsigned POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [POS_W-1:0] width,
  output logic [POS_W-1:0] pos,
  output logic             wrap
);
  logic [POS_W:0]   sum;
  logic [POS_W:0]   limit;
  logic [POS_W-1:0] pos_d;
  logic [POS_W-1:0] pos_q;

  // Position counts pixels from the start of the current row pair.
  always_comb begin
    sum   = {1'b0, pos_q} + (POS_W+1)'(4);
    limit = {width, 1'b0};
    wrap  = (sum >= limit);
    pos_d = pos_q;
    if (adv) begin
      pos_d = wrap ? '0 : sum[POS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (adv) begin
      pos_q <= pos_d;
    end
  end

  assign pos = pos_q;
endmodule

// File: rtl/mpd_lane_map.sv
module mpd_lane_map #(
  parameter int unsigned POS_W = 7,
  parameter int unsigned AW    = 4,
  parameter int unsigned OFF   = 0
) (
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] width,
  output logic [1:0]       bank,
  output logic [AW-1:0]    addr
);
  logic [POS_W-1:0] pix;
  logic [POS_W-1:0] col;
  logic             lower;

  // Row within the pair decides upper/lower; column bit 1 picks even/odd bank.
  always_comb begin
    pix   = pos + POS_W'(OFF);
    lower = (pix >= width);
    col   = lower ? (pix - width) : pix;
    bank  = {lower, col[1]};
    addr  = col[AW+1:2];
  end
endmodule

// File: rtl/mpd_row_steer.sv
module mpd_row_steer
  import mpd_pkg::*;
#(
  parameter int unsigned MAX_ROW = 64,
  localparam int unsigned POS_W  = $clog2(2 * MAX_ROW),
  localparam int unsigned AW     = $clog2(MAX_ROW) - 2,
  localparam int unsigned BEAT_W = PIX_PER * PIX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    beat_valid,
  input  logic [BEAT_W-1:0]       beat_data,
  input  logic [POS_W-1:0]        row_width,
  output logic [NBANK-1:0]        bank_we,
  output logic [NBANK*AW-1:0]     bank_addr,
  output logic [NBANK*PAIR_W-1:0] bank_wdata,
  output logic                    pair_ready
);
  logic [POS_W-1:0]        pos;
  logic                    wrap;
  logic [1:0]              lane_bank [PAIRS];
  logic [AW-1:0]           lane_addr [PAIRS];

  logic [NBANK-1:0]        we_d,    we_q;
  logic [NBANK*AW-1:0]     addr_d,  addr_q;
  logic [NBANK*PAIR_W-1:0] data_d,  data_q;
  logic                    rdy_d,   rdy_q;

  mpd_pos_track #(.POS_W(POS_W)) u_track (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (beat_valid),
    .width (row_width),
    .pos   (pos),
    .wrap  (wrap)
  );

  for (genvar g = 0; g < PAIRS; g++) begin : g_lane
    mpd_lane_map #(.POS_W(POS_W), .AW(AW), .OFF(2 * g)) u_map (
      .pos   (pos),
      .width (row_width),
      .bank  (lane_bank[g]),
      .addr  (lane_addr[g])
    );
  end

  // Two pairs of one beat never share a bank, so the merge is a plain steer.
  always_comb begin
    we_d   = '0;
    addr_d = addr_q;
    data_d = data_q;
    rdy_d  = beat_valid && wrap;
    if (beat_valid) begin
      for (int l = 0; l < PAIRS; l++) begin
        we_d[lane_bank[l]]                   = 1'b1;
        addr_d[lane_bank[l]*AW +: AW]        = lane_addr[l];
        data_d[lane_bank[l]*PAIR_W +: PAIR_W] = beat_data[l*PAIR_W +: PAIR_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q  <= '0;
      rdy_q <= 1'b0;
    end else begin
      we_q  <= we_d;
      rdy_q <= rdy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (beat_valid) begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign bank_we    = we_q;
  assign bank_addr  = addr_q;
  assign bank_wdata = data_q;
  assign pair_ready = rdy_q;
endmodule

// File: rtl/mpd_row_steer_chk.sv
module mpd_row_steer_chk #(
  parameter int unsigned AW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            beat_valid,
  input logic [3:0]      bank_we,
  input logic [4*AW-1:0] bank_addr,
  input logic            pair_ready
);
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(beat_valid) |-> (bank_we == 4'b0000)); // R7
  AST_TWO_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(beat_valid) |-> ($countones(bank_we) == 2)); // R7
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pair_ready |=> !pair_ready); // R6
  AST_READY_WITH_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    pair_ready |-> (bank_we[2] || bank_we[3])); // R6
  AST_CROSS_HEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we[0] && bank_we[2]) |-> (bank_addr[2*AW +: AW] == '0)); // R4
  AST_NO_ODD_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank_we[1] && bank_we[2])); // R4
  AST_UP_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we[0] && bank_we[1]) |-> (bank_addr[0 +: AW] == bank_addr[AW +: AW])); // R2
endmodule

bind mpd_row_steer mpd_row_steer_chk #(.AW(4)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .beat_valid (beat_valid),
  .bank_we    (bank_we),
  .bank_addr  (bank_addr),
  .pair_ready (pair_ready)
);

// File: tb/test_mpd_row_steer.sv
module test_mpd_row_steer;
  typedef struct {
    logic [3:0]       we;
    logic [3:0][3:0]  addr;
    logic [3:0][31:0] data;
    bit               rdy;
    string            tag;
  } exp_t;

  logic         clk;
  logic         rst_n;
  logic         beat_valid;
  logic [63:0]  beat_data;
  logic [6:0]   row_width;
  logic [3:0]   bank_we;
  logic [15:0]  bank_addr;
  logic [127:0] bank_wdata;
  logic         pair_ready;

  exp_t   sb[$];
  int     n_chk;
  int     n_bad;
  int     mpos;
  int     seq;
  bit     done;

  mpd_row_steer i_mpd_row_steer (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (beat_valid),
    .beat_data  (beat_data),
    .row_width  (row_width),
    .bank_we    (bank_we),
    .bank_addr  (bank_addr),
    .bank_wdata (bank_wdata),
    .pair_ready (pair_ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // Model: place each pair from its own pixel index within the row pair.
  task automatic send_beat();
    exp_t e;
    int   rows [2];
    logic [63:0] d;
    e.we = '0; e.addr = '0; e.data = '0; e.rdy = 0;
    for (int i = 0; i < 4; i++) d[16*i +: 16] = 16'(seq * 4 + i);
    seq++;
    for (int l = 0; l < 2; l++) begin
      int p, r, c, b;
      p = mpos + 2 * l;
      r = (p < int'(row_width)) ? 0 : 1;
      c = (r == 0) ? p : p - int'(row_width);
      b = 2 * r + ((c / 2) % 2);
      rows[l] = r;
      e.we[b]   = 1'b1;
      e.addr[b] = 4'(c / 4);
      e.data[b] = d[32*l +: 32];
    end
    e.tag = (rows[0] != rows[1]) ? "R4" : (rows[0] == 0 ? "R2" : "R3");
    mpos += 4;
    if (mpos >= 2 * int'(row_width)) begin
      mpos = 0;
      e.rdy = 1;
    end
    @(negedge clk);
    beat_valid = 1'b1;
    beat_data  = d;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      beat_valid = 1'b0;
      beat_data  = 64'hdead_beef_0bad_f00d;
    end
  endtask

  task automatic do_reset(input int w);
    @(negedge clk);
    beat_valid = 1'b0;
    rst_n = 1'b0;
    row_width = 7'(w);
    mpos = 0;
    #3;
    check(bank_we == 4'b0 && pair_ready == 1'b0, "R1", "outputs in reset",
          {59'b0, pair_ready, bank_we}, 64'h0);
    idle(2);
    rst_n = 1'b1;
    @(posedge clk); #5;
    check(bank_we == 4'b0 && pair_ready == 1'b0, "R1", "outputs after reset",
          {59'b0, pair_ready, bank_we}, 64'h0);
  endtask

  task automatic run(input int w, input int pairs, input bit gaps);
    int beats;
    do_reset(w);
    beats = pairs * 2 * w / 4;
    for (int k = 0; k < beats; k++) begin
      send_beat();
      if (gaps && (k % 3 == 1)) idle(2);
    end
    idle(3);
  endtask

  // Monitor: mid-cycle, pop one expected beat per observed write cycle.
  always begin
    @(posedge clk);
    #5;
    if (rst_n && (bank_we != 4'b0 || pair_ready)) begin
      if (sb.size() == 0) begin
        check(0, "R7", "unexpected write", {59'b0, pair_ready, bank_we}, 64'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(bank_we == e.we, "R7", "write enables", {60'b0, bank_we}, {60'b0, e.we});
        check(pair_ready == e.rdy, "R6", "pair ready", {63'b0, pair_ready}, {63'b0, e.rdy});
        for (int b = 0; b < 4; b++) begin
          if (e.we[b]) begin
            check(bank_addr[4*b +: 4] == e.addr[b], "R5", $sformatf("addr bank %0d", b),
                  {60'b0, bank_addr[4*b +: 4]}, {60'b0, e.addr[b]});
            check(bank_wdata[32*b +: 32] == e.data[b], e.tag, $sformatf("data bank %0d (R8)", b),
                  {32'b0, bank_wdata[32*b +: 32]}, {32'b0, e.data[b]});
          end
        end
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      check(0, "R7", "watchdog expired", 64'h0, 64'h1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; seq = 0; mpos = 0; done = 0;
    rst_n = 1'b0;
    beat_valid = 1'b0;
    beat_data  = '0;
    row_width  = 7'd48;
    idle(2);
    run(48, 2, 1'b0);   // aligned, R2 R3 R5 R6
    run(22, 2, 1'b1);   // straddling beat with gaps, R4 R3 R7
    run(10, 3, 1'b0);   // straddling, short rows back to back
    run(4, 3, 1'b1);    // minimum width
    // Reset mid-pair: next beat must restart at upper row column 0 (R1).
    do_reset(24);
    for (int k = 0; k < 5; k++) send_beat();
    idle(3);
    run(24, 1, 1'b0);
    idle(4);
    check(sb.size() == 0, "R7", "undelivered beats", 64'(sb.size()), 64'h0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule